// File: doc/BRIEF.md
# Calibrated Temperature/Code Converter

This block maps a temperature in whole degrees Celsius to the 8-bit code a thermal sensor reports, and maps a code back to a temperature. The mapping is linear and depends on calibration trim held in a 16-bit fused word. One of three calibration schemes is chosen per request: a fixed offset, a one-point trim that shifts by the measured low-point code, or a two-point trim that scales between the 25 °C and 85 °C calibration points. A trim that looks implausible is replaced by a fallback value supplied on a control pin before any arithmetic is done.

A request enters through a valid/ready handshake and the answer leaves through another. Only one request is in flight at a time. `in_ready` is high only while the block is idle. A result waits on `out_valid`, with value and error flag frozen, for as long as the consumer holds `out_ready` low. Requests in the two-point mode go through a sequential divider and take about twenty cycles longer than the others. An optional range check rejects values outside the sensor's usable window. Every result is clamped to 8 bits, and the error flag marks clamping, range rejection and a zero divisor.

Top module: `tcc_top`

## Requirements
- R1: `in_ready` is 1 only when no request is held. A request is accepted on a clock edge with `in_valid` and `in_ready` both high. After acceptance `in_ready` stays 0 until the result has been taken.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_result` and `out_err` hold their values. The cycle after `out_valid && out_ready`, `out_valid` is 0 and `in_ready` is 1.
- R3: The primary trim t1 is `in_trim[7:0]` and the secondary trim t2 is `in_trim[15:8]`. If t1 < 40, t1 > 100, or t2 != 0, then t1 is replaced by `cfg_fallback`.
- R4: With `in_mode` 2'b00 or 2'b11 (fixed offset), direction 0 (`in_dir`=0, temperature to code) gives v+50, and direction 1 (code to temperature) gives v−50.
- R5: With `in_mode` 2'b01 (one-point), direction 0 gives v+t1−25 and direction 1 gives v−t1+25.
- R6: With `in_mode` 2'b10 (two-point), direction 0 gives (v−25)·(t2−t1)/60 + t1. The division is signed and truncates toward zero.
- R7: With `in_mode` 2'b10, direction 1 gives (v−t1)·60/(t2−t1) + 25. The division is signed and truncates toward zero.
- R8: In two-point mode, direction 1, if t2 equals the effective t1, the result is 0 with `out_err`=1.
- R9: With `in_rngchk`=1, a direction-0 value outside 25..125 or a direction-1 value outside 75..175 gives result 0 with `out_err`=1. This applies in every mode.
- R10: A computed value below 0 gives result 0 and a value above 255 gives result 255, both with `out_err`=1. A value in range gives `out_err`=0.
- R11: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request can be taken |
| in_dir | input | 1 | 0: temperature to code, 1: code to temperature |
| in_value | input | 8 | Temperature or code to convert |
| in_trim | input | 16 | Fused trim word (t2 high byte, t1 low byte) |
| in_mode | input | 2 | Calibration scheme select |
| in_rngchk | input | 1 | Enable the input window check |
| cfg_fallback | input | 8 | Substitute for an implausible t1 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Converted value |
| out_err | output | 1 | Clamp, range or zero-divisor error |

## Verification
The assertions assume that a producer does not change the request fields in the cycle it is accepted. They also assume that `cfg_fallback` is stable from acceptance until the result is taken, because the checker and the datapath both read the trim as captured at the handshake. The bench drives every request field at a falling edge, removes `in_valid` right after the accepting edge, and sets the fallback only between transactions. Back-pressure is applied by holding `out_ready` low for a few cycles on a regular subset of the sweep.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_DIV  = 2'd2,
    ST_OUT  = 2'd3
  } tcc_state_t;

  localparam logic [1:0] MODE_FIXA = 2'b00;
  localparam logic [1:0] MODE_ONE  = 2'b01;
  localparam logic [1:0] MODE_TWO  = 2'b10;
  localparam logic [1:0] MODE_FIXB = 2'b11;
endpackage

// File: rtl/tcc_trim.sv
module tcc_trim #(
  parameter int DW       = 8,
  parameter int TRIM_MIN = 40,
  parameter int TRIM_MAX = 100
) (
  input  logic [2*DW-1:0] trim_word,
  input  logic [DW-1:0]   fallback,
  output logic [DW-1:0]   t1,
  output logic [DW-1:0]   t2
);
  logic [DW-1:0] raw1;
  logic          bad;

  assign raw1 = trim_word[DW-1:0];
  assign t2   = trim_word[2*DW-1:DW];
  assign bad  = (raw1 < DW'(TRIM_MIN)) || (raw1 > DW'(TRIM_MAX)) || (t2 != '0);
  assign t1   = bad ? fallback : raw1;
endmodule

// File: rtl/tcc_divider.sv
module tcc_divider #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem;
  logic [W-1:0]  quo;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [W:0]    rem_sh;
  logic [W:0]    rem_sub;
  logic          fits;

  assign rem_sh  = {rem, quo[W-1]};
  assign rem_sub = rem_sh - {1'b0, divisor};
  assign fits    = rem_sh >= {1'b0, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        quo  <= dividend;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? rem_sub[W-1:0] : rem_sh[W-1:0];
        quo  <= {quo[W-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;
endmodule

// File: rtl/tcc_sat.sv
module tcc_sat #(
  parameter int DW = 8,
  parameter int WW = 20
) (
  input  logic signed [WW-1:0] x,
  output logic [DW-1:0]        y,
  output logic                 over
);
  localparam logic signed [WW-1:0] TOPV = WW'((1 << DW) - 1);

  always_comb begin
    if (x < 0) begin
      y    = '0;
      over = 1'b1;
    end else if (x > TOPV) begin
      y    = '1;
      over = 1'b1;
    end else begin
      y    = x[DW-1:0];
      over = 1'b0;
    end
  end
endmodule

// File: rtl/tcc_top.sv
module tcc_top
  import tcc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LO_CAL   = 25,
  parameter int HI_CAL   = 85,
  parameter int FIX_OFS  = 50,
  parameter int TRIM_MIN = 40,
  parameter int TRIM_MAX = 100,
  parameter int T_MIN    = 25,
  parameter int T_MAX    = 125,
  parameter int C_MIN    = 75,
  parameter int C_MAX    = 175
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_dir,
  input  logic [DW-1:0]   in_value,
  input  logic [2*DW-1:0] in_trim,
  input  logic [1:0]      in_mode,
  input  logic            in_rngchk,
  input  logic [DW-1:0]   cfg_fallback,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_result,
  output logic            out_err
);
  localparam int WW = 2 * DW + 4;
  localparam logic signed [WW-1:0] K_LO   = WW'(LO_CAL);
  localparam logic signed [WW-1:0] K_SPAN = WW'(HI_CAL - LO_CAL);
  localparam logic signed [WW-1:0] K_FIX  = WW'(FIX_OFS);

  tcc_state_t state;

  logic            r_dir;
  logic [DW-1:0]   r_v;
  logic [2*DW-1:0] r_trim;
  logic [1:0]      r_mode;
  logic            r_rng;
  logic [DW-1:0]   r_fb;
  logic            r_neg;
  logic signed [WW-1:0] r_off;
  logic [DW-1:0]   res_q;
  logic            err_q;

  logic [DW-1:0]   t1;
  logic [DW-1:0]   t2;

  tcc_trim #(.DW(DW), .TRIM_MIN(TRIM_MIN), .TRIM_MAX(TRIM_MAX)) u_trim (
    .trim_word (r_trim),
    .fallback  (r_fb),
    .t1        (t1),
    .t2        (t2)
  );

  logic signed [WW-1:0] sv, st1, st2, diff;
  logic signed [WW-1:0] num, den, off, direct_val;
  logic [WW-1:0]        num_abs, den_abs;
  logic                 is_two, is_one, rng_bad, zero_div, force_err;

  assign sv   = WW'(r_v);
  assign st1  = WW'(t1);
  assign st2  = WW'(t2);
  assign diff = st2 - st1;

  assign is_two = (r_mode == MODE_TWO);
  assign is_one = (r_mode == MODE_ONE);

  assign rng_bad = r_rng && (r_dir ? ((r_v < DW'(C_MIN)) || (r_v > DW'(C_MAX)))
                                   : ((r_v < DW'(T_MIN)) || (r_v > DW'(T_MAX))));
  assign zero_div  = is_two && r_dir && (diff == 0);
  assign force_err = rng_bad || zero_div;

  always_comb begin
    if (r_dir) begin
      num = (sv - st1) * K_SPAN;
      den = diff;
      off = K_LO;
    end else begin
      num = (sv - K_LO) * diff;
      den = K_SPAN;
      off = st1;
    end
  end

  always_comb begin
    if (is_one) direct_val = r_dir ? (sv - st1 + K_LO) : (sv + st1 - K_LO);
    else        direct_val = r_dir ? (sv - K_FIX) : (sv + K_FIX);
  end

  assign num_abs = num[WW-1] ? -num : num;
  assign den_abs = den[WW-1] ? -den : den;

  logic          div_start, div_done;
  logic [WW-1:0] div_q;

  assign div_start = (state == ST_EVAL) && is_two && !force_err;

  tcc_divider #(.W(WW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (num_abs),
    .divisor  (den_abs),
    .done     (div_done),
    .quotient (div_q)
  );

  logic signed [WW-1:0] q_s, sat_x;
  logic [DW-1:0]        sat_y;
  logic                 sat_over;

  assign q_s   = r_neg ? -$signed(div_q) : $signed(div_q);
  assign sat_x = (state == ST_DIV) ? (q_s + r_off) : direct_val;

  tcc_sat #(.DW(DW), .WW(WW)) u_sat (
    .x    (sat_x),
    .y    (sat_y),
    .over (sat_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      r_dir  <= 1'b0;
      r_v    <= '0;
      r_trim <= '0;
      r_mode <= MODE_FIXA;
      r_rng  <= 1'b0;
      r_fb   <= '0;
      r_neg  <= 1'b0;
      r_off  <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            r_dir  <= in_dir;
            r_v    <= in_value;
            r_trim <= in_trim;
            r_mode <= in_mode;
            r_rng  <= in_rngchk;
            r_fb   <= cfg_fallback;
            state  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (force_err) begin
            res_q <= '0;
            err_q <= 1'b1;
            state <= ST_OUT;
          end else if (is_two) begin
            r_neg <= num[WW-1] ^ den[WW-1];
            r_off <= off;
            state <= ST_DIV;
          end else begin
            res_q <= sat_y;
            err_q <= sat_over;
            state <= ST_OUT;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            res_q <= sat_y;
            err_q <= sat_over;
            state <= ST_OUT;
          end
        end
        default: begin
          if (out_ready) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready   = (state == ST_IDLE);
  assign out_valid  = (state == ST_OUT);
  assign out_result = res_q;
  assign out_err    = err_q;
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_dir,
  input logic [DW-1:0]   in_value,
  input logic [2*DW-1:0] in_trim,
  input logic [1:0]      in_mode,
  input logic            in_rngchk,
  input logic [DW-1:0]   cfg_fallback,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DW-1:0]   out_result,
  input logic            out_err
);
  logic          pend_force;
  logic [DW-1:0] lo, hi, eff1;
  logic          win_bad, zdiv;

  assign lo   = in_trim[DW-1:0];
  assign hi   = in_trim[2*DW-1:DW];
  assign eff1 = ((lo < DW'(40)) || (lo > DW'(100)) || (hi != '0)) ? cfg_fallback : lo;
  assign win_bad = in_rngchk && (in_dir ? ((in_value < DW'(75)) || (in_value > DW'(175)))
                                        : ((in_value < DW'(25)) || (in_value > DW'(125))));
  assign zdiv = (in_mode == 2'b10) && in_dir && (hi == eff1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_force <= 1'b0;
    else if (in_valid && in_ready) pend_force <= win_bad || zdiv;
  end

  a_r1_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r1_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_err)));

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  a_r10_err_on_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> ((out_result == '0) || (out_result == '1)));

  // R8 and R9: zero divisor or window violation forces 0 with error
  a_r9_forced_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pend_force) |-> (out_err && (out_result == '0)));
endmodule

bind tcc_top tcc_checker #(.DW(DW)) u_tcc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_dir       (in_dir),
  .in_value     (in_value),
  .in_trim      (in_trim),
  .in_mode      (in_mode),
  .in_rngchk    (in_rngchk),
  .cfg_fallback (cfg_fallback),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_err      (out_err)
);

// File: tb/tcc_top_bench.sv
`timescale 1ns/1ps
module tcc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dir = 1'b0;
  logic [7:0]  in_value = '0;
  logic [15:0] in_trim = '0;
  logic [1:0]  in_mode = '0;
  logic        in_rngchk = 1'b0;
  logic [7:0]  cfg_fallback = 8'd55;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_result;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done_all = 1'b0;

  always #2 clk = ~clk;

  tcc_top u_tcc_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_value(in_value), .in_trim(in_trim), .in_mode(in_mode),
    .in_rngchk(in_rngchk), .cfg_fallback(cfg_fallback), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_err(out_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input bit dir, input int v, input logic [15:0] trim,
                       input logic [1:0] mode, input bit rng, input int fb,
                       output int r, output bit e, output string tag);
    int t1, t2, d, x;
    t1 = trim[7:0];
    t2 = trim[15:8];
    if (t1 < 40 || t1 > 100 || t2 != 0) t1 = fb;
    if (rng && (dir ? (v < 75 || v > 175) : (v < 25 || v > 125))) begin
      r = 0; e = 1'b1; tag = "R9"; return;
    end
    if (mode == 2'b10) begin
      d = t2 - t1;
      if (dir) begin
        if (d == 0) begin r = 0; e = 1'b1; tag = "R8"; return; end
        x = (v - t1) * 60 / d + 25; tag = "R7";
      end else begin
        x = (v - 25) * d / 60 + t1; tag = "R6";
      end
    end else if (mode == 2'b01) begin
      x = dir ? v - t1 + 25 : v + t1 - 25; tag = "R5";
    end else begin
      x = dir ? v - 50 : v + 50; tag = "R4";
    end
    if (x < 0) begin r = 0; e = 1'b1; tag = "R10"; end
    else if (x > 255) begin r = 255; e = 1'b1; tag = "R10"; end
    else begin r = x; e = 1'b0; end
  endtask

  task automatic run_txn(input bit dir, input int v, input logic [15:0] trim,
                         input logic [1:0] mode, input bit rng, input int fb,
                         input int hold, input string force_tag);
    int r_exp, wait_n;
    bit e_exp;
    string tag;
    logic [7:0] held_r;
    logic held_e;
    model(dir, v, trim, mode, rng, fb, r_exp, e_exp, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    cfg_fallback = 8'(fb);
    in_dir = dir; in_value = 8'(v); in_trim = trim; in_mode = mode; in_rngchk = rng;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (in_ready) check(1'b0, "R1", int'(in_ready), 0);
    wait_n = 0;
    while (!out_valid && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    held_r = out_result;
    held_e = out_err;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(out_valid && out_result == held_r && out_err == held_e, "R2",
            int'(out_result), int'(held_r));
    end
    check(out_valid && int'(out_result) == r_exp && out_err == e_exp, tag,
          int'(out_err) * 1000 + int'(out_result), int'(e_exp) * 1000 + r_exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    if (out_valid || !in_ready) check(1'b0, "R2", int'(out_valid), 0);
  endtask

  function automatic logic [15:0] trim_of(input int i);
    case (i)
      0: trim_of = 16'h0037;
      1: trim_of = 16'h0010;
      2: trim_of = 16'h5A3C;
      3: trim_of = 16'h3700;
      default: trim_of = 16'h0064;
    endcase
  endfunction

  function automatic int fb_of(input int i);
    case (i)
      1: fb_of = 48;
      4: fb_of = 60;
      default: fb_of = 55;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11: idle state out of reset
    check(in_ready == 1'b1 && out_valid == 1'b0, "R11", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R11", int'(in_ready), 1);

    // R3: trim substitution in one-point mode, direction 0
    run_txn(1'b0, 100, 16'h0010, 2'b01, 1'b0, 55, 0, "R3");  // 130
    run_txn(1'b0, 100, 16'h0041, 2'b01, 1'b0, 55, 0, "R3");  // 140
    run_txn(1'b0, 100, 16'h0165, 2'b01, 1'b0, 70, 0, "R3");  // t2!=0, 145
    // R9: window edges
    run_txn(1'b0, 25,  16'h0037, 2'b00, 1'b1, 55, 0, "R9");
    run_txn(1'b0, 24,  16'h0037, 2'b00, 1'b1, 55, 0, "R9");
    run_txn(1'b0, 125, 16'h0037, 2'b00, 1'b1, 55, 0, "R9");
    run_txn(1'b0, 126, 16'h0037, 2'b00, 1'b1, 55, 0, "R9");
    run_txn(1'b1, 75,  16'h0037, 2'b01, 1'b1, 55, 0, "R9");
    run_txn(1'b1, 74,  16'h0037, 2'b01, 1'b1, 55, 0, "R9");
    run_txn(1'b1, 175, 16'h0037, 2'b01, 1'b1, 55, 0, "R9");
    run_txn(1'b1, 176, 16'h0037, 2'b01, 1'b1, 55, 0, "R9");
    // R8: zero divisor
    run_txn(1'b1, 120, 16'h3700, 2'b10, 1'b0, 55, 1, "R8");
    // R10: clamp both ways
    run_txn(1'b0, 240, 16'h0037, 2'b00, 1'b0, 55, 0, "R10");
    run_txn(1'b1, 10,  16'h0037, 2'b00, 1'b0, 55, 0, "R10");
    // R7: negative quotient truncates toward zero
    run_txn(1'b1, 54, 16'h5A3C, 2'b10, 1'b0, 55, 0, "R7");

    // sweep: trims x modes x directions x window check x values
    for (int ti = 0; ti < 5; ti++)
      for (int m = 0; m < 4; m++)
        for (int d = 0; d < 2; d++)
          for (int rc = 0; rc < 2; rc++)
            for (int v = 0; v < 256; v += 5)
              run_txn(d[0], v, trim_of(ti), m[1:0], rc[0], fb_of(ti),
                      (v % 4 == 1) ? 2 : 0, "");

    done_all = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_all) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule